// File: doc/BRIEF.md
# Interrupt Control Register Unit

This block holds one 8-bit control and status register for a small processor core. It also contains the logic that turns that register into a single interrupt request. Three event sources feed it: a timer-overflow pulse, an external-edge pulse and a 4-bit input port that is watched for changes. A fourth input is one line that carries the OR of all other peripheral interrupts. Each source has a sticky flag. The flags latch whatever the enable bits hold. Software reads the register and clears the flags by writing 0 to them.

The port watcher compares the synchronized pins with a snapshot. The snapshot is taken whenever the core reads the port, which the core signals with `port_rd`. While the pins differ from the snapshot, the port-change flag is set again on every cycle. A software clear therefore has no lasting effect until a port read refreshes the snapshot.

Top module: `irq_ctl_reg`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 0x00 and `irq_req` is low. All eight bits reset to 0, including the port-change flag.
- R2: The register bit map, MSB first, is:
  - bit 7: global enable
  - bit 6: peripheral enable
  - bit 5: timer enable
  - bit 4: external enable
  - bit 3: port-change enable
  - bit 2: timer flag
  - bit 1: external flag
  - bit 0: port-change flag

  A write with `wr_en` high loads all eight bits at the clock edge. Only a flag event in the same cycle overrides the written value. The new value is visible on `rd_data` after that edge.
- R3: A `tmr_ovf` pulse sets bit 2 and an `ext_evt` pulse sets bit 1 at the next edge. This happens with any value in bits 7 to 3.
- R4: A flag stays set until software writes it to 0. If a set event and a write of 0 reach the same flag in one cycle, the flag ends up set.
- R5: `irq_req` is the registered value of: bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND `periph_irq`)). It is one cycle behind the register and the `periph_irq` input.
- R6: With bit 7 at 0, `irq_req` is low one cycle later, whatever the other bits and inputs hold.
- R7: With bit 6 at 0, `periph_irq` has no effect on `irq_req`.
- R8: The port pins pass through a two-flop synchronizer. A pin that differs from the snapshot sets bit 0 on the third clock edge after the change, and not before.
- R9: While the mismatch persists, bit 0 is set again each cycle, so a write of 0 does not clear it. A `port_rd` pulse loads the snapshot with the synchronized pins. After that pulse, a write of 0 clears bit 0 and bit 0 stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register value |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_evt | input | 1 | External edge event pulse |
| port_pins | input | 4 | Asynchronous watched port pins |
| port_rd | input | 1 | Port read strobe, refreshes the snapshot |
| periph_irq | input | 1 | OR of the other peripheral interrupts |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
A wrong flag or enable bit shows on `rd_data` at the edge after the cause. It shows on `irq_req` one edge after that. The bench sweeps all 256 register values against both levels of `periph_irq` and compares the request with the formula. A stale or wrong port snapshot shows as bit 0 that cannot be cleared, or that sets with no pin change. The directed port sequence detects it within three cycles of the pin change or the port read.

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg #(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              tmr_ovf,
  input  logic              ext_evt,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              port_rd,
  input  logic              periph_irq,
  output logic              irq_req
);
  logic [7:0]        ctl_q;
  logic [7:0]        ctl_d;
  logic [PORT_W-1:0] sync1_q, sync2_q, snap_q;
  logic              mismatch;
  logic              irq_d, irq_q;

  always_ff @(posedge clk) begin
    sync1_q <= port_pins;
    sync2_q <= sync1_q;
  end

  assign mismatch = (sync2_q != snap_q);

  always_comb begin
    ctl_d = wr_en ? wr_data : ctl_q;
    ctl_d[2] = ctl_d[2] | tmr_ovf;
    ctl_d[1] = ctl_d[1] | ext_evt;
    ctl_d[0] = ctl_d[0] | mismatch;
  end

  assign irq_d = ctl_q[7] & ((ctl_q[5] & ctl_q[2]) | (ctl_q[4] & ctl_q[1]) |
                             (ctl_q[3] & ctl_q[0]) | (ctl_q[6] & periph_irq));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      snap_q <= sync2_q;
      irq_q  <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      if (port_rd) snap_q <= sync2_q;
      irq_q <= irq_d;
    end
  end

  assign rd_data = ctl_q;
  assign irq_req = irq_q;
endmodule

module irq_ctl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       tmr_ovf,
  input logic       ext_evt,
  input logic       periph_irq,
  input logic       mismatch,
  input logic       irq_req
);
  AST_TMR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) tmr_ovf |=> rd_data[2]); // R3
  AST_EXT_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) ext_evt |=> rd_data[1]); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (rd_data[2] && !wr_en) |=> rd_data[2]); // R4
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tmr_ovf && !ext_evt && !mismatch) |=> (rd_data == $past(wr_data))); // R2
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n) !rd_data[7] |=> !irq_req); // R6
  AST_PERIPH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7:6] == 2'b10 && rd_data[5:0] == 6'd0) |=> !irq_req); // R7
endmodule

bind irq_ctl_reg irq_ctl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .tmr_ovf(tmr_ovf), .ext_evt(ext_evt), .periph_irq(periph_irq),
  .mismatch(mismatch), .irq_req(irq_req)
);

// File: tb/irq_ctl_reg_bench.sv
`timescale 1ns/1ps
module irq_ctl_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tmr_ovf = 1'b0;
  logic       ext_evt = 1'b0;
  logic [3:0] port_pins = '0;
  logic       port_rd = 1'b0;
  logic       periph_irq = 1'b0;
  logic       irq_req;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  irq_ctl_reg u_irq_ctl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tmr_ovf(tmr_ovf), .ext_evt(ext_evt), .port_pins(port_pins), .port_rd(port_rd),
    .periph_irq(periph_irq), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    step();
    wr_en = 1'b0;
  endtask

  function automatic logic expect_irq(input logic [7:0] v, input logic p);
    return v[7] & ((v[5] & v[2]) | (v[4] & v[1]) | (v[3] & v[0]) | (v[6] & p));
  endfunction

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) step();
    rst_n = 1'b1;
    step();
    check("R1 reset rd_data", rd_data, 8'h00);
    check("R1 reset irq_req", {7'd0, irq_req}, 8'h00);

    for (int v = 0; v < 256; v++) begin
      for (int p = 0; p < 2; p++) begin
        periph_irq = p[0];
        write_reg(v[7:0]);
        check("R2 write readback", rd_data, v[7:0]);
        step();
        if (!v[7])
          check("R6 global gate", {7'd0, irq_req}, 8'h00);
        else if (!v[6])
          check("R7 periph gate", {7'd0, irq_req}, {7'd0, expect_irq(v[7:0], 1'b0)});
        else
          check("R5 irq formula", {7'd0, irq_req}, {7'd0, expect_irq(v[7:0], p[0])});
      end
    end
    periph_irq = 1'b0;

    write_reg(8'h00);
    step();
    tmr_ovf = 1'b1;
    step();
    tmr_ovf = 1'b0;
    check("R3 timer flag with enables off", rd_data, 8'h04);
    write_reg(8'hF8);
    check("R3 flags cleared", rd_data, 8'hF8);
    ext_evt = 1'b1;
    step();
    ext_evt = 1'b0;
    check("R3 external flag with enables on", rd_data, 8'hFA);
    write_reg(8'h04);
    repeat (3) step();
    check("R4 flag held", rd_data, 8'h04);
    ext_evt = 1'b1;
    write_reg(8'h00);
    ext_evt = 1'b0;
    check("R4 set wins over clear", rd_data, 8'h02);
    write_reg(8'h00);
    check("R4 software clear", rd_data, 8'h00);

    write_reg(8'hA4);
    check("R5 request latency one cycle", {7'd0, irq_req}, 8'h00);
    step();
    check("R5 request asserted", {7'd0, irq_req}, 8'h01);
    write_reg(8'h00);
    step();

    port_pins = 4'b0100;
    step();
    step();
    check("R8 no flag before third edge", rd_data, 8'h00);
    step();
    check("R8 mismatch sets flag", rd_data, 8'h01);
    write_reg(8'h00);
    check("R9 clear blocked by mismatch", rd_data, 8'h01);
    step();
    check("R9 flag re-set each cycle", rd_data, 8'h01);
    port_rd = 1'b1;
    step();
    port_rd = 1'b0;
    write_reg(8'h00);
    check("R9 clear after port read", rd_data, 8'h00);
    repeat (3) step();
    check("R9 stays clear", rd_data, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule